// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer Counter

This block is a 16-bit up-counter with two clock sources. In timer use it advances on an internal clock-enable tick. In event-counter use it advances once for each high-to-low transition of an external count pin. A run input gates both sources. When the count wraps from all ones to zero, a sticky overflow flag is set. The interrupt request is that flag gated by an interrupt enable.

A single 16-bit capture/reload register serves two purposes, and a mode input chooses between them. In capture mode, a falling edge on an external trigger pin stores the live count in the register, provided the trigger enable is high. In autoreload mode, software writes a start value into the register. On every overflow the count restarts from that value, and trigger edges are ignored.

Both registers can be written a byte at a time through write strobes. Both external pins pass through a synchronizer before edge detection.

Top module: `cr_timer16`

## Requirements
- R1: With `run_i` at 0 and no count write, `count_o` holds its value, whatever `tick_i` and `cnt_pin_i` do.
- R2: With `ext_sel_i` at 0 and `run_i` at 1, the count rises by one at each clock edge where `tick_i` is 1. Activity on `cnt_pin_i` has no effect.
- R3: With `ext_sel_i` at 1 and `run_i` at 1, a 1-to-0 change on `cnt_pin_i` raises the count by one at the third rising clock edge after the change. `tick_i` has no effect.
- R4: An increment from FFFFh gives a new count, and in capture mode that count is 0000h. The same increment sets `ovf_flag_o`. `irq_o` is 1 exactly when `ovf_flag_o` and `irq_en_i` are both 1.
- R5: With `cap_mode_i` at 1 and `trig_en_i` at 1, a 1-to-0 change on `trig_pin_i` copies the count into `crr_o` at the third rising edge after the change. With `trig_en_i` at 0, trigger edges leave `crr_o` unchanged. A bus write to the capture/reload register takes priority over a capture in the same cycle.
- R6: `ovf_flag_o` stays 1 until a cycle with `ovf_clr_i` at 1. If a clear and an overflow fall in the same cycle, the flag ends at 1.
- R7: With `cap_mode_i` at 0, an overflow loads the count from `crr_o` instead of 0000h, and it sets the flag.
- R8: With `cap_mode_i` at 0, trigger edges never change `crr_o`.
- R9: A pin held low after a falling edge yields exactly one event, so the count rises by one only.
- R10: Write strobe bit 0 selects bits 7:0 and bit 1 selects bits 15:8. A count write wins over an increment due in the same cycle: the unwritten byte holds, no increment happens, and no overflow is flagged.
- R11: A capture and an increment in the same cycle store the count from before the increment.
- R12: After reset, `count_o`, `crr_o`, `ovf_flag_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal timer clock enable |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| trig_pin_i | input | 1 | External trigger pin, asynchronous |
| run_i | input | 1 | Counting enable |
| ext_sel_i | input | 1 | 1 = count pin edges, 0 = timer tick |
| cap_mode_i | input | 1 | 1 = capture, 0 = autoreload |
| trig_en_i | input | 1 | Enables capture on trigger edges |
| irq_en_i | input | 1 | Interrupt enable |
| cnt_we_i | input | 2 | Count byte write strobes (bit 0 low byte) |
| cnt_wdata_i | input | 16 | Count write data |
| crr_we_i | input | 2 | Capture/reload byte write strobes (bit 0 low byte) |
| crr_wdata_i | input | 16 | Capture/reload write data |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| count_o | output | 16 | Current count |
| crr_o | output | 16 | Capture/reload register |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench holds the count pin low for many cycles after one edge. A detector that fired on level rather than on transition would count on and on. It drives a clear into the very cycle of an overflow, where a design that lets the clear win would drop the event. It writes one count byte while an increment from FFFFh is due. A wrong priority would either wrap, setting the flag, or disturb the other byte. It also fires a trigger while the counter runs every cycle, so capturing the post-increment value shows up as an off-by-one. Finally it sends trigger edges in autoreload mode, where a capture would corrupt the reload value.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;

  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_PIN  = 1'b1
  } cnt_src_e;

  typedef enum logic {
    CR_RELOAD  = 1'b0,
    CR_CAPTURE = 1'b1
  } cr_mode_e;

  typedef struct packed {
    logic inc;
    logic cap;
  } tmr_evt_t;

endpackage

// File: rtl/crt_rst_sync.sv
module crt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  // R9: one pin transition gives a single-cycle event
  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/crt_count_core.sv
module crt_count_core #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              reload_mode_i,
  input  logic [CNT_W-1:0]  reload_val_i,
  input  logic [NBYTES-1:0] wr_be_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] step_val;
  logic [NBYTES-1:0][BYTE_W-1:0] lane_d;
  logic wr_any;
  logic at_max;

  assign wr_any = |wr_be_i;
  assign at_max = &cnt_q;

  always_comb begin
    if (!inc_i) begin
      step_val = cnt_q;
    end else if (at_max) begin
      step_val = reload_mode_i ? reload_val_i : '0;
    end else begin
      step_val = cnt_q + 1'b1;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_d[b] = wr_be_i[b] ? wdata_i[b*BYTE_W +: BYTE_W] :
                       wr_any     ? cnt_q[b*BYTE_W +: BYTE_W]   :
                                    step_val[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= lane_d;
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = inc_i & at_max & ~wr_any;

  // R1: no increment and no write keeps the count
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !wr_any) |=> (cnt_q == $past(cnt_q)));

  // R7: an overflow in reload mode restarts from the reload value
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && reload_mode_i) |=> (cnt_q == $past(reload_val_i)));

endmodule

// File: rtl/crt_capreg.sv
module crt_capreg #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ev_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [NBYTES-1:0] wr_be_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  crr_o
);

  logic [CNT_W-1:0] crr_q;
  logic [NBYTES-1:0][BYTE_W-1:0] lane_d;
  logic wr_any;

  assign wr_any = |wr_be_i;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_d[b] = wr_be_i[b] ? wdata_i[b*BYTE_W +: BYTE_W] :
                       (cap_ev_i && !wr_any) ? count_i[b*BYTE_W +: BYTE_W] :
                                               crr_q[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crr_q <= '0;
    end else begin
      crr_q <= lane_d;
    end
  end

  assign crr_o = crr_q;

  // R11: a capture stores the count seen before that edge's increment
  assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev_i && !wr_any) |=> (crr_q == $past(count_i)));

endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import cr_timer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NBYTES      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              run_i,
  input  logic              ext_sel_i,
  input  logic              cap_mode_i,
  input  logic              trig_en_i,
  input  logic              irq_en_i,
  input  logic [NBYTES-1:0] cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic [NBYTES-1:0] crr_we_i,
  input  logic [CNT_W-1:0]  crr_wdata_i,
  input  logic              ovf_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  crr_o,
  output logic              ovf_flag_o,
  output logic              irq_o
);

  logic     rst_sync_n;
  logic     cnt_fall;
  logic     trig_fall;
  logic     wrap;
  logic     flag_q;
  logic     flag_d;
  cnt_src_e src;
  cr_mode_e mode;
  tmr_evt_t evt;
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] crr_w;

  crt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_pin (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (cnt_pin_i),
    .fall_o (cnt_fall)
  );

  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_pin (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (trig_pin_i),
    .fall_o (trig_fall)
  );

  assign src  = cnt_src_e'(ext_sel_i);
  assign mode = cr_mode_e'(cap_mode_i);

  always_comb begin
    evt.inc = run_i & ((src == SRC_PIN) ? cnt_fall : tick_i);
    evt.cap = (mode == CR_CAPTURE) & trig_en_i & trig_fall;
  end

  crt_count_core #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_core (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .inc_i         (evt.inc),
    .reload_mode_i (mode == CR_RELOAD),
    .reload_val_i  (crr_w),
    .wr_be_i       (cnt_we_i),
    .wdata_i       (cnt_wdata_i),
    .count_o       (count_w),
    .wrap_o        (wrap)
  );

  crt_capreg #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_crr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_ev_i (evt.cap),
    .count_i  (count_w),
    .wr_be_i  (crr_we_i),
    .wdata_i  (crr_wdata_i),
    .crr_o    (crr_w)
  );

  // overflow flag: a new overflow beats a clear in the same cycle
  always_comb begin
    if (wrap) begin
      flag_d = 1'b1;
    end else if (ovf_clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign count_o    = count_w;
  assign crr_o      = crr_w;
  assign ovf_flag_o = flag_q;
  assign irq_o      = flag_q & irq_en_i;

  // R4: a wrap always leaves the flag set
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wrap |=> flag_q);

  // R6: the flag stays until cleared
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_q && !ovf_clr_i) |=> flag_q);

  // R8: reload mode never alters the register except by bus write
  assert_no_capture_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cap_mode_i && (crr_we_i == '0)) |=> (crr_w == $past(crr_w)));

endmodule

// File: tb/cr_timer16_tb.sv
module cr_timer16_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        cnt_pin_i;
  logic        trig_pin_i;
  logic        run_i;
  logic        ext_sel_i;
  logic        cap_mode_i;
  logic        trig_en_i;
  logic        irq_en_i;
  logic [1:0]  cnt_we_i;
  logic [15:0] cnt_wdata_i;
  logic [1:0]  crr_we_i;
  logic [15:0] crr_wdata_i;
  logic        ovf_clr_i;
  logic [15:0] count_o;
  logic [15:0] crr_o;
  logic        ovf_flag_o;
  logic        irq_o;

  int n_chk;
  int n_fail;
  bit done;

  cr_timer16 u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .cnt_pin_i   (cnt_pin_i),
    .trig_pin_i  (trig_pin_i),
    .run_i       (run_i),
    .ext_sel_i   (ext_sel_i),
    .cap_mode_i  (cap_mode_i),
    .trig_en_i   (trig_en_i),
    .irq_en_i    (irq_en_i),
    .cnt_we_i    (cnt_we_i),
    .cnt_wdata_i (cnt_wdata_i),
    .crr_we_i    (crr_we_i),
    .crr_wdata_i (crr_wdata_i),
    .ovf_clr_i   (ovf_clr_i),
    .count_o     (count_o),
    .crr_o       (crr_o),
    .ovf_flag_o  (ovf_flag_o),
    .irq_o       (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_wdata_i = v;
    cnt_we_i    = 2'b11;
    step(1);
    cnt_we_i    = 2'b00;
  endtask

  task automatic t_reset;
    chk("R12 count", 32'(count_o), 32'h0);
    chk("R12 crr", 32'(crr_o), 32'h0);
    chk("R12 flag", 32'(ovf_flag_o), 32'h0);
    chk("R12 irq", 32'(irq_o), 32'h0);
  endtask

  task automatic t_timer;
    cap_mode_i = 1'b1;
    wr_cnt(16'h0010);
    run_i = 1'b1;
    ext_sel_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick_i = (i % 3 != 0);
      cnt_pin_i = ~cnt_pin_i;
      step(1);
    end
    tick_i = 1'b0;
    run_i = 1'b0;
    cnt_pin_i = 1'b1;
    chk("R2 timer ticks", 32'(count_o), 32'h0015);
    step(4);
  endtask

  task automatic t_hold;
    run_i = 1'b0;
    tick_i = 1'b1;
    step(5);
    tick_i = 1'b0;
    chk("R1 hold", 32'(count_o), 32'h0015);
  endtask

  task automatic t_counter;
    run_i = 1'b1;
    ext_sel_i = 1'b1;
    tick_i = 1'b1;
    cnt_pin_i = 1'b0;
    step(2);
    chk("R3 before edge lands", 32'(count_o), 32'h0015);
    step(1);
    chk("R3 edge counted", 32'(count_o), 32'h0016);
    step(5);
    chk("R9 held low counts once", 32'(count_o), 32'h0016);
    cnt_pin_i = 1'b1;
    step(3);
    cnt_pin_i = 1'b0;
    step(3);
    chk("R3 second edge", 32'(count_o), 32'h0017);
    cnt_pin_i = 1'b1;
    step(4);
    run_i = 1'b0;
    tick_i = 1'b0;
    ext_sel_i = 1'b0;
  endtask

  task automatic t_overflow;
    cap_mode_i = 1'b1;
    irq_en_i = 1'b0;
    wr_cnt(16'hFFFE);
    run_i = 1'b1;
    tick_i = 1'b1;
    step(1);
    tick_i = 1'b0;
    chk("R4 no flag before wrap", 32'(ovf_flag_o), 32'h0);
    tick_i = 1'b1;
    step(1);
    tick_i = 1'b0;
    chk("R4 wrap to zero", 32'(count_o), 32'h0000);
    chk("R4 flag set", 32'(ovf_flag_o), 32'h1);
    chk("R4 irq masked", 32'(irq_o), 32'h0);
    irq_en_i = 1'b1;
    #1;
    chk("R4 irq enabled", 32'(irq_o), 32'h1);
    step(3);
    chk("R6 flag sticky", 32'(ovf_flag_o), 32'h1);
    ovf_clr_i = 1'b1;
    step(1);
    ovf_clr_i = 1'b0;
    chk("R6 flag cleared", 32'(ovf_flag_o), 32'h0);
    chk("R4 irq drops", 32'(irq_o), 32'h0);
    wr_cnt(16'hFFFF);
    tick_i = 1'b1;
    ovf_clr_i = 1'b1;
    step(1);
    tick_i = 1'b0;
    ovf_clr_i = 1'b0;
    chk("R6 set beats clear", 32'(ovf_flag_o), 32'h1);
    ovf_clr_i = 1'b1;
    step(1);
    ovf_clr_i = 1'b0;
    irq_en_i = 1'b0;
    run_i = 1'b0;
  endtask

  task automatic t_write_prio;
    run_i = 1'b1;
    tick_i = 1'b1;
    wr_cnt(16'hFFFF);
    chk("R10 write beats increment", 32'(count_o), 32'hFFFF);
    chk("R10 no overflow on write", 32'(ovf_flag_o), 32'h0);
    cnt_wdata_i = 16'h1200;
    cnt_we_i = 2'b10;
    step(1);
    cnt_we_i = 2'b00;
    tick_i = 1'b0;
    run_i = 1'b0;
    chk("R10 high byte only", 32'(count_o), 32'h12FF);
    chk("R10 still no overflow", 32'(ovf_flag_o), 32'h0);
  endtask

  task automatic t_capture;
    cap_mode_i = 1'b1;
    trig_en_i = 1'b1;
    wr_cnt(16'h5A5A);
    trig_pin_i = 1'b0;
    step(2);
    chk("R5 not yet captured", 32'(crr_o), 32'h0);
    step(1);
    chk("R5 captured", 32'(crr_o), 32'h5A5A);
    trig_pin_i = 1'b1;
    step(3);
    wr_cnt(16'h7777);
    trig_en_i = 1'b0;
    trig_pin_i = 1'b0;
    step(4);
    chk("R5 disabled trigger", 32'(crr_o), 32'h5A5A);
    trig_pin_i = 1'b1;
    step(3);
  endtask

  task automatic t_cap_inc;
    cap_mode_i = 1'b1;
    trig_en_i = 1'b1;
    run_i = 1'b1;
    tick_i = 1'b1;
    wr_cnt(16'h0100);
    trig_pin_i = 1'b0;
    step(3);
    chk("R11 pre-increment capture", 32'(crr_o), 32'h0102);
    chk("R11 count moved on", 32'(count_o), 32'h0103);
    run_i = 1'b0;
    tick_i = 1'b0;
    trig_pin_i = 1'b1;
    trig_en_i = 1'b0;
    step(3);
  endtask

  task automatic t_reload;
    cap_mode_i = 1'b0;
    crr_wdata_i = 16'h1234;
    crr_we_i = 2'b11;
    step(1);
    crr_we_i = 2'b00;
    wr_cnt(16'hFFFE);
    run_i = 1'b1;
    tick_i = 1'b1;
    step(2);
    run_i = 1'b0;
    tick_i = 1'b0;
    chk("R7 reload value", 32'(count_o), 32'h1234);
    chk("R7 flag on reload", 32'(ovf_flag_o), 32'h1);
    ovf_clr_i = 1'b1;
    step(1);
    ovf_clr_i = 1'b0;
    trig_en_i = 1'b1;
    trig_pin_i = 1'b0;
    step(4);
    chk("R8 no capture in reload mode", 32'(crr_o), 32'h1234);
    trig_pin_i = 1'b1;
    trig_en_i = 1'b0;
    step(3);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    tick_i = 1'b0;
    cnt_pin_i = 1'b1;
    trig_pin_i = 1'b1;
    run_i = 1'b0;
    ext_sel_i = 1'b0;
    cap_mode_i = 1'b1;
    trig_en_i = 1'b0;
    irq_en_i = 1'b0;
    cnt_we_i = 2'b00;
    cnt_wdata_i = '0;
    crr_we_i = 2'b00;
    crr_wdata_i = '0;
    ovf_clr_i = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_timer();
    t_hold();
    t_counter();
    t_overflow();
    t_write_prio();
    t_capture();
    t_cap_inc();
    t_reload();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule